// File: doc/BRIEF.md
# Warp Issue-Efficiency Statistics Counters

This block watches the warp scheduler of one multiprocessor and keeps running totals that show how well that multiprocessor keeps its issue slots busy. Every clock cycle it receives a status flag set for each warp slot: whether the warp is resident (active), whether it could issue this cycle (eligible), a three-bit code giving why it cannot issue, and which of the two scheduler slices owns it. From these it builds a set of saturating totals. They cover resident warps, issuable warps and issue holes. They also cover long holes, cycles in which no slice could issue, cycles in which exactly one slice could issue, and five stall-cause categories.

Each warp slot has a private run-length counter. This counter measures how many consecutive cycles an active warp has gone without being able to issue. Warps stuck past the long-latency threshold are counted separately, which separates memory and barrier stalls from short pipeline bubbles. A mode input chooses the update rule for the stall-cause totals. In one setting they update on every cycle, so that the stall-cause totals add up to the hole total. In the other setting they update only on cycles where no warp at all could issue. Software samples the totals one at a time through a select/data read port and zeroes them all with a synchronous clear.

Top module: `warp_issue_stats`

## Requirements
- R1: Each cycle the resident-warp total (read select 0) grows by the number of set bits in `active_i`, from 0 to 48.
- R2: A warp counts as eligible only if its `active_i` bit is also set; each cycle the eligible total (select 1) grows by that masked count, so it never exceeds the resident-warp total.
- R3: Each cycle the hole total (select 2) grows by the number of active warps that are not eligible.
- R4: A warp's ineligible run restarts whenever it is eligible or inactive. On the 33rd and every later consecutive cycle of being active and ineligible, the warp adds 1 to the long-hole total (select 3). The run counter stops at 33.
- R5: The no-issue total (select 4) grows by 1 on each cycle in which no active warp is eligible in either slice.
- R6: The single-slice total (select 5) grows by 1 on each cycle in which exactly one slice owns an active eligible warp. `slice_i` bit w = 0 places warp w in slice 0, and bit w = 1 places it in slice 1.
- R7: Every active, ineligible warp adds 1 to exactly one stall-cause total. It uses its code from `reason_i[3w+2:3w]`: 0 instruction fetch (select 6), 1 execution dependency (select 7), 2 data request (select 8), 3 texture (select 9), 4 synchronization (select 10). Codes 5 to 7 count as synchronization.
- R8: With `every_cycle_i` = 1 the stall-cause totals update on every cycle. In that case their sum equals the hole total as long as that total has not saturated. With `every_cycle_i` = 0 they update only on cycles where no active warp is eligible.
- R9: Every total saturates at 2^CW-1 and never wraps.
- R10: `clr_i` high at a clock edge leaves all eleven totals zero after that edge, and the clear overrides any accumulation in that cycle. Run counters are not affected.
- R11: `rd_data_o` shows the total picked by `rd_sel_i` (0 to 10) in the same cycle, with no register in the path. Selects 11 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all totals |
| every_cycle_i | input | 1 | 1: stall causes counted every cycle; 0: only on no-issue cycles |
| active_i | input | NWARP | Per-warp resident flag |
| eligible_i | input | NWARP | Per-warp issuable flag |
| slice_i | input | NWARP | Per-warp scheduler slice |
| reason_i | input | 3*NWARP | Per-warp stall-cause code |
| rd_sel_i | input | 4 | Read select |
| rd_data_o | output | CW | Selected total |

## Verification
Most internal faults in this block show up at the read port one clock after the faulty cycle, because every total is a single register stage behind the inputs. A corrupted run counter is slower to appear. It can stay hidden for up to 33 cycles before it shows as a wrong long-hole total, so the stimulus holds warps ineligible for long stretches and then breaks the runs. A wrong cause mapping or a wrong mode rule breaks the equality between the cause sum and the hole total on the very next cycle. A saturation or clear fault appears only once a total reaches its ceiling or a clear hits a busy cycle, so the bench uses a narrow counter width and clears while warps are active.

// File: rtl/wis_pkg.sv
`timescale 1ns/1ps
// Shared constants for the warp issue statistics block: read-select map,
// stall-cause codes and the folding of unused codes onto a category.
package wis_pkg;
    localparam int NRSN   = 5;   // stall-cause categories
    localparam int NCNT   = 11;  // totals held
    localparam int RSN_W  = 3;   // per-warp cause code width
    localparam int SELW   = 4;   // read select width

    // read select indices
    localparam int SEL_ACT  = 0;
    localparam int SEL_ELIG = 1;
    localparam int SEL_HOLE = 2;
    localparam int SEL_LONG = 3;
    localparam int SEL_ZERO = 4;
    localparam int SEL_ONE  = 5;
    localparam int SEL_RSN0 = 6;

    typedef enum logic [RSN_W-1:0] {
        CAUSE_FETCH = 3'd0,
        CAUSE_DEP   = 3'd1,
        CAUSE_DATA  = 3'd2,
        CAUSE_TEX   = 3'd3,
        CAUSE_SYNC  = 3'd4
    } cause_e;

    // Fold a raw cause code onto a category index; spare codes go to sync.
    function automatic logic [2:0] cause_bucket(input logic [RSN_W-1:0] code);
        if (code > CAUSE_SYNC) return 3'(CAUSE_SYNC);
        return code;
    endfunction
endpackage

// File: rtl/wis_warp_age.sv
`timescale 1ns/1ps
// Per-warp ineligible run-length counter.
// Counts consecutive cycles the warp is active and not eligible, stops at
// LIM+1, and restarts on any eligible or inactive cycle. Flags a long hole
// when the current cycle is beyond the LIM-th of the run.
// Assumes elig_i is already masked with act_i.
module wis_warp_age #(
    parameter int LIM  = 32,
    parameter int AGEW = $clog2(LIM + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act_i,
    input  logic            elig_i,
    output logic            long_o,
    output logic [AGEW-1:0] age_o
);
    logic [AGEW-1:0] age_q;
    logic            stalled;

    assign stalled = act_i && !elig_i;
    // current run length is age_q+1, long when it exceeds LIM
    assign long_o  = stalled && (age_q >= AGEW'(LIM));
    assign age_o   = age_q;

    // advance, hold at the cap, or restart the run
    always_ff @(posedge clk) begin
        if (!rst_n || !stalled)            age_q <= '0;
        else if (age_q < AGEW'(LIM + 1))   age_q <= age_q + AGEW'(1);
    end
endmodule

// File: rtl/wis_tally.sv
`timescale 1ns/1ps
// Combinational per-cycle tally of the warp status vectors.
// Produces resident, eligible, hole and long-hole counts, per-cause counts
// of stalled warps, and a per-slice "has issuable warp" flag.
// Assumes two scheduler slices, selected by one bit per warp.
module wis_tally
    import wis_pkg::*;
#(
    parameter int NWARP = 48,
    parameter int CNTW  = $clog2(NWARP + 1)
) (
    input  logic [NWARP-1:0]            active_i,
    input  logic [NWARP-1:0]            elig_m_i,
    input  logic [NWARP-1:0]            long_i,
    input  logic [NWARP-1:0]            slice_i,
    input  logic [RSN_W*NWARP-1:0]      reason_i,
    output logic [CNTW-1:0]             n_act_o,
    output logic [CNTW-1:0]             n_elig_o,
    output logic [CNTW-1:0]             n_hole_o,
    output logic [CNTW-1:0]             n_long_o,
    output logic [NRSN-1:0][CNTW-1:0]   n_rsn_o,
    output logic [1:0]                  slice_any_o
);
    // walk every warp slot and bump the matching counts
    always_comb begin
        n_act_o     = '0;
        n_elig_o    = '0;
        n_hole_o    = '0;
        n_long_o    = '0;
        n_rsn_o     = '0;
        slice_any_o = '0;
        for (int w = 0; w < NWARP; w++) begin
            if (active_i[w]) n_act_o = n_act_o + CNTW'(1);
            if (elig_m_i[w]) begin
                n_elig_o = n_elig_o + CNTW'(1);
                slice_any_o[slice_i[w]] = 1'b1;
            end
            if (active_i[w] && !elig_m_i[w]) begin
                n_hole_o = n_hole_o + CNTW'(1);
                n_rsn_o[cause_bucket(reason_i[RSN_W*w +: RSN_W])] =
                    n_rsn_o[cause_bucket(reason_i[RSN_W*w +: RSN_W])] + CNTW'(1);
            end
            if (long_i[w]) n_long_o = n_long_o + CNTW'(1);
        end
    end
endmodule

// File: rtl/wis_sat_acc.sv
`timescale 1ns/1ps
// Saturating accumulator with synchronous clear.
// Adds inc_i every cycle, holds at all-ones instead of wrapping; clear wins.
module wis_sat_acc #(
    parameter int CW = 40,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [IW-1:0] inc_i,
    output logic [CW-1:0] acc_o
);
    logic [CW:0] sum;

    assign sum = {1'b0, acc_o} + (CW+1)'(inc_i);

    // accumulate, saturate on carry, or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) acc_o <= '0;
        else if (sum[CW])    acc_o <= '1;
        else                 acc_o <= sum[CW-1:0];
    end
endmodule

// File: rtl/warp_issue_stats.sv
`timescale 1ns/1ps
// Warp issue-efficiency statistics for one multiprocessor.
// Takes per-warp active/eligible/slice/cause status each cycle and keeps
// eleven saturating totals readable through a combinational select port.
// Assumes the status vectors are stable around the clock edge; eligible
// bits of inactive warps are ignored.
module warp_issue_stats
    import wis_pkg::*;
#(
    parameter int NWARP   = 48,
    parameter int CW      = 40,
    parameter int AGE_LIM = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    every_cycle_i,
    input  logic [NWARP-1:0]        active_i,
    input  logic [NWARP-1:0]        eligible_i,
    input  logic [NWARP-1:0]        slice_i,
    input  logic [RSN_W*NWARP-1:0]  reason_i,
    input  logic [SELW-1:0]         rd_sel_i,
    output logic [CW-1:0]           rd_data_o
);
    localparam int CNTW = $clog2(NWARP + 1);
    localparam int AGEW = $clog2(AGE_LIM + 2);

    logic [NWARP-1:0]             elig_m;
    logic [NWARP-1:0]             long_v;
    logic [NWARP-1:0][AGEW-1:0]   age_all;
    logic [CNTW-1:0]              n_act, n_elig, n_hole, n_long;
    logic [NRSN-1:0][CNTW-1:0]    n_rsn;
    logic [1:0]                   slice_any;
    logic                         cause_gate;
    logic [NCNT-1:0][CNTW-1:0]    inc_v;
    logic [NCNT-1:0][CW-1:0]      acc;

    assign elig_m = eligible_i & active_i;

    // one run-length counter per warp slot
    for (genvar w = 0; w < NWARP; w++) begin : g_age
        wis_warp_age #(.LIM(AGE_LIM), .AGEW(AGEW)) u_age (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_i  (active_i[w]),
            .elig_i (elig_m[w]),
            .long_o (long_v[w]),
            .age_o  (age_all[w])
        );
    end

    wis_tally #(.NWARP(NWARP), .CNTW(CNTW)) u_tally (
        .active_i    (active_i),
        .elig_m_i    (elig_m),
        .long_i      (long_v),
        .slice_i     (slice_i),
        .reason_i    (reason_i),
        .n_act_o     (n_act),
        .n_elig_o    (n_elig),
        .n_hole_o    (n_hole),
        .n_long_o    (n_long),
        .n_rsn_o     (n_rsn),
        .slice_any_o (slice_any)
    );

    assign cause_gate = every_cycle_i || (slice_any == 2'b00);

    // per-total increment for this cycle
    always_comb begin
        inc_v           = '0;
        inc_v[SEL_ACT]  = n_act;
        inc_v[SEL_ELIG] = n_elig;
        inc_v[SEL_HOLE] = n_hole;
        inc_v[SEL_LONG] = n_long;
        inc_v[SEL_ZERO] = CNTW'(slice_any == 2'b00);
        inc_v[SEL_ONE]  = CNTW'(^slice_any);
        for (int r = 0; r < NRSN; r++)
            inc_v[SEL_RSN0 + r] = cause_gate ? n_rsn[r] : '0;
    end

    for (genvar k = 0; k < NCNT; k++) begin : g_acc
        wis_sat_acc #(.CW(CW), .IW(CNTW)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i (inc_v[k]),
            .acc_o (acc[k])
        );
    end

    // combinational read mux, out-of-range selects read zero
    always_comb begin
        rd_data_o = '0;
        if (int'(rd_sel_i) < NCNT) rd_data_o = acc[rd_sel_i];
    end
endmodule

// File: rtl/wis_checker.sv
`timescale 1ns/1ps
// Property checker for warp_issue_stats, attached by bind below.
module wis_checker
    import wis_pkg::*;
#(
    parameter int NWARP   = 48,
    parameter int CW      = 40,
    parameter int AGE_LIM = 32,
    parameter int AGEW    = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        clr_i,
    input logic [NCNT-1:0][CW-1:0]     acc,
    input logic [NWARP-1:0][AGEW-1:0]  age_all
);
    p_elig_le_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc[SEL_ELIG] <= acc[SEL_ACT]);

    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc == '0));

    p_no_wrap_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> acc[SEL_ACT] >= $past(acc[SEL_ACT]));

    p_no_wrap_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> acc[SEL_HOLE] >= $past(acc[SEL_HOLE]));

    p_zero_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ({1'b0, acc[SEL_ZERO]} <= {1'b0, $past(acc[SEL_ZERO])} + (CW+1)'(1)));

    // R5/R6: no cycle is both a no-issue and a single-slice cycle
    p_zero_one_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> !((acc[SEL_ZERO] != $past(acc[SEL_ZERO])) &&
                     (acc[SEL_ONE]  != $past(acc[SEL_ONE]))));

    for (genvar w = 0; w < NWARP; w++) begin : g_age_chk
        p_age_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            age_all[w] <= AGEW'(AGE_LIM + 1));
    end
endmodule

bind warp_issue_stats wis_checker #(
    .NWARP(NWARP), .CW(CW), .AGE_LIM(AGE_LIM), .AGEW(AGEW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .acc     (acc),
    .age_all (age_all)
);

// File: tb/warp_issue_stats_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random status vectors,
// compared against a cycle model kept in bench functions.
module warp_issue_stats_test;
    localparam int NW   = 48;
    localparam int CW   = 12;
    localparam longint MAXV = (64'd1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_i = 1'b0;
    logic              every_cycle_i = 1'b1;
    logic [NW-1:0]     active_i = '0;
    logic [NW-1:0]     eligible_i = '0;
    logic [NW-1:0]     slice_i = '0;
    logic [3*NW-1:0]   reason_i = '0;
    logic [3:0]        rd_sel_i = '0;
    logic [CW-1:0]     rd_data_o;

    int nchk = 0;
    int nerr = 0;
    longint exp_v [0:10];
    int     age_m [0:NW-1];
    bit     inv_ok = 1'b1;
    bit     done = 1'b0;

    warp_issue_stats #(.NWARP(NW), .CW(CW), .AGE_LIM(32)) uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .every_cycle_i(every_cycle_i),
        .active_i(active_i), .eligible_i(eligible_i), .slice_i(slice_i),
        .reason_i(reason_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic string tag_of(int k);
        case (k)
            0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
            4: return "R5"; 5: return "R6"; default: return "R7";
        endcase
    endfunction

    function automatic longint sat_add(longint a, longint b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    function automatic int bucket(logic [2:0] c);
        return (c > 3'd4) ? 4 : int'(c);
    endfunction

    // advance the reference model by one clock edge
    task automatic model_step();
        longint inc [0:10];
        bit s0 = 0, s1 = 0;
        for (int k = 0; k < 11; k++) inc[k] = 0;
        for (int w = 0; w < NW; w++) begin
            bit a = active_i[w];
            bit e = eligible_i[w] & a;
            if (a) inc[0]++;
            if (e) begin
                inc[1]++;
                if (slice_i[w]) s1 = 1; else s0 = 1;
            end
            if (a && !e) begin
                inc[2]++;
                if (age_m[w] >= 32) inc[3]++;
                inc[6 + bucket(reason_i[3*w +: 3])]++;
                if (age_m[w] < 33) age_m[w]++;
            end else age_m[w] = 0;
        end
        inc[4] = (!s0 && !s1) ? 1 : 0;
        inc[5] = (s0 ^ s1) ? 1 : 0;
        if (!(every_cycle_i || (!s0 && !s1)))
            for (int r = 6; r < 11; r++) inc[r] = 0;
        if (clr_i) begin
            for (int k = 0; k < 11; k++) exp_v[k] = 0;
            inv_ok = 1'b1;
        end else begin
            for (int k = 0; k < 11; k++) exp_v[k] = sat_add(exp_v[k], inc[k]);
            if (!every_cycle_i) inv_ok = 1'b0;
        end
    endtask

    task automatic check(string tag, longint act, longint expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // read every total plus two out-of-range selects, with the clock low
    task automatic read_all();
        longint rsum = 0;
        longint hole = 0;
        for (int k = 0; k < 11; k++) begin
            rd_sel_i = 4'(k);
            #0.25;
            check(tag_of(k), longint'(rd_data_o), exp_v[k]);
            if (k >= 6) rsum += longint'(rd_data_o);
            if (k == 2) hole = longint'(rd_data_o);
        end
        rd_sel_i = 4'd11; #0.25;
        check("R11 sel11", longint'(rd_data_o), 0);
        rd_sel_i = 4'd15; #0.25;
        check("R11 sel15", longint'(rd_data_o), 0);
        // R8 invariant: cause sum equals hole total in every-cycle mode
        if (inv_ok && hole < MAXV) check("R8 cause-sum", rsum, hole);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        read_all();
    endtask

    function automatic logic [NW-1:0] rnd48();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [3*NW-1:0] rnd_rsn();
        return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 11; k++) exp_v[k] = 0;
        for (int w = 0; w < NW; w++) age_m[w] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_all();                     // reset state: all zero (R1..R11)

        // R4: one warp held ineligible 40 cycles -> long holes from cycle 33
        active_i = 48'h1; eligible_i = '0; reason_i = '0;
        repeat (40) tick();
        check("R4 long after 40", exp_v[3], 8);
        eligible_i = 48'h1; tick();     // run restarts
        eligible_i = '0; repeat (5) tick();

        // R7: spare codes fold to sync; every code on its own warp
        active_i = 48'hFF; eligible_i = '0;
        for (int w = 0; w < 8; w++) reason_i[3*w +: 3] = 3'(w);
        tick();

        // R6: eligible only in slice 1, then both slices
        slice_i = 48'hF0; eligible_i = 48'h10; tick();
        eligible_i = 48'h11; tick();
        // R2: eligible without active is ignored
        active_i = 48'h0F; eligible_i = 48'hF0; tick();

        // R8: no-issue-only mode
        every_cycle_i = 1'b0;
        eligible_i = 48'h01; repeat (3) tick();
        eligible_i = '0; repeat (3) tick();

        // R10: clear while busy
        every_cycle_i = 1'b1;
        active_i = '1; clr_i = 1'b1; tick();
        clr_i = 1'b0;
        check("R10 cleared act", exp_v[0], 0);

        // R9: all warps active long enough to saturate
        eligible_i = '0; reason_i = rnd_rsn();
        repeat (100) tick();
        check("R9 saturated", exp_v[0], MAXV);
        clr_i = 1'b1; tick(); clr_i = 1'b0;

        // random phase with periodic clears and held stretches
        for (int n = 0; n < 1500; n++) begin
            if ((n % 100) < 50) begin
                active_i   = rnd48();
                eligible_i = rnd48() & rnd48() & rnd48();
                if (($urandom() % 4) == 0) eligible_i = '0;
            end else begin
                eligible_i = (($urandom() % 8) == 0) ? rnd48() & rnd48() : '0;
            end
            slice_i  = rnd48();
            reason_i = rnd_rsn();
            if ((n % 200) == 0) every_cycle_i = $urandom() % 2;
            clr_i = (($urandom() % 97) == 0);
            tick();
        end
        clr_i = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule